// File: doc/BRIEF.md
# Instruction Fetch and Sequencing Unit

This block fetches instructions and steers the program counter for a small interpreter core. The core uses 16-bit instructions stored in byte-wide memory. Each instruction is read as two bytes through a single byte-read port. The byte at the lower address becomes the upper half of the instruction word. The block then decides where the counter goes next.

In the execute cycle the two register operands named by the word are looked up in an external register file. Against them the block resolves these instruction families:

- unconditional jumps: the system-address form `0nnn` and the plain jump `1nnn`;
- four compare-and-skip forms.

A true compare skips the following instruction. Every other opcode only moves the counter on by one instruction and raises a one-cycle illegal flag.

Each fetch is started by a `start` input. When the counter has been updated, the block raises a one-cycle `done` pulse. Together with it, the registered instruction word and its decoded fields are handed to the execute stage. If `start` is held high, instructions run back to back, one every three cycles.

Top module: `fetchSeqUnit`

## Requirements
- R1: While reset is active and directly after it, the counter reads 0x200, `done` and `illegal` are low and no memory read is requested.
- R2: After `start` is sampled high, the block requests the byte at the counter. In the next cycle it requests the byte at counter+1. The instruction word is (first byte << 8) | second byte.
- R3: An instruction that neither jumps nor skips moves the counter forward by 2. `done` is high for exactly one cycle, three clock edges after `start` was sampled.
- R4: Opcode 0x1nnn, and opcode 0x0nnn except 0x00E0 and 0x00EE, load the counter with nnn (bits 11:0) instead of advancing it.
- R5: Opcode 0x3xkk moves the counter by 4 when register x (bits 11:8) equals kk (bits 7:0). Otherwise it moves the counter by 2.
- R6: Opcode 0x4xkk moves the counter by 4 when register x differs from kk. Otherwise it moves the counter by 2.
- R7: Opcode 0x5xy0 moves the counter by 4 when register x equals register y (bits 7:4). Opcode 0x9xy0 does the same when they differ. A non-zero low nibble makes either one unhandled.
- R8: The counter is 12 bits wide. Advances, skips and the second-byte address all wrap modulo 4096.
- R9: Unhandled opcodes, including 0x00E0, 0x00EE and 0x5xyN/0x9xyN with N≠0, move the counter by 2. They raise `illegal` in the same single cycle as `done`.
- R10: While `done` is high, the field outputs carry x = word[11:8], y = word[7:4], kk = word[7:0], nnn = word[11:0] and n = word[3:0] of the executed word.
- R11: In the execute cycle no memory read is requested. The register-index outputs carry the x and y fields of the word being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fetching the next instruction |
| memAddr | output | 12 | Byte address of the read port |
| memRdEn | output | 1 | Read request; data is returned on the next cycle |
| memRdData | input | 8 | Byte returned one cycle after the request |
| regIdxX | output | 4 | Register-file index for operand x |
| regIdxY | output | 4 | Register-file index for operand y |
| regValX | input | 8 | Value of register regIdxX (combinational) |
| regValY | input | 8 | Value of register regIdxY (combinational) |
| pc | output | 12 | Program counter |
| instrWord | output | 16 | Last executed instruction word |
| fieldX | output | 4 | Field x of instrWord |
| fieldY | output | 4 | Field y of instrWord |
| fieldKk | output | 8 | Field kk of instrWord |
| fieldNnn | output | 12 | Field nnn of instrWord |
| fieldN | output | 4 | Field n of instrWord |
| done | output | 1 | One-cycle pulse: instruction executed |
| illegal | output | 1 | One-cycle pulse with done for unhandled opcodes |

## Verification
Two functions can meet in one edge: a skip and the 12-bit wrap of the counter. The bench causes this by jumping to 0xFFE and running a compare-and-skip there that succeeds. A correct design then reaches 0x002; a design that loses the carry from the skip does not. A second collision is a fetch whose two bytes straddle the end of memory. This happens after a jump to 0xFFF, and the check is that the low byte of the word comes from address 0x000.

// File: rtl/fetchSeqPkg.sv
`timescale 1ns/1ps
package fetchSeqPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_EXECUTE
  } fetchState_e;

  typedef struct packed {
    logic issueHi;
    logic issueLo;
    logic execute;
  } fetchStrobe_t;

  localparam logic [3:0] OP_SYS    = 4'h0;
  localparam logic [3:0] OP_JUMP   = 4'h1;
  localparam logic [3:0] OP_SEQ_K  = 4'h3;
  localparam logic [3:0] OP_SNE_K  = 4'h4;
  localparam logic [3:0] OP_SEQ_R  = 4'h5;
  localparam logic [3:0] OP_SNE_R  = 4'h9;
  localparam logic [15:0] WORD_CLEAR  = 16'h00E0;
  localparam logic [15:0] WORD_RETURN = 16'h00EE;
endpackage

// File: rtl/fetchSeqCtrl.sv
`timescale 1ns/1ps
module fetchSeqCtrl
  import fetchSeqPkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output fetchStrobe_t strobe
);
  fetchState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:     if (start) stateNext = ST_FETCH_HI;
      ST_FETCH_HI: stateNext = ST_FETCH_LO;
      ST_FETCH_LO: stateNext = ST_EXECUTE;
      ST_EXECUTE:  stateNext = start ? ST_FETCH_HI : ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobe         = '0;
    strobe.issueHi = (state == ST_FETCH_HI);
    strobe.issueLo = (state == ST_FETCH_LO);
    strobe.execute = (state == ST_EXECUTE);
  end

  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issueHi |=> strobe.issueLo); // R2
  AST_LO_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issueLo |=> strobe.execute); // R2
endmodule

// File: rtl/fetchSeqPath.sv
`timescale 1ns/1ps
module fetchSeqPath
  import fetchSeqPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RESET_PC = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fetchStrobe_t      strobe,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        regValX,
  input  logic [7:0]        regValY,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic [3:0]        regIdxX,
  output logic [3:0]        regIdxY,
  output logic [ADDR_W-1:0] pc,
  output logic [15:0]       instrWord,
  output logic              done,
  output logic              illegal
);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] NEXT_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PC_INIT  = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0] pcReg, execPc, pcNext;
  logic [7:0]        hiByte;
  logic [15:0]       wordReg, curWord;
  logic              doneReg, illReg, wasJump, wasSkip;
  logic [3:0]        opc;
  logic              isJump, isSkip, isLegal, lowZero;

  assign curWord = {hiByte, memRdData};
  assign opc     = curWord[15:12];
  assign lowZero = (curWord[3:0] == 4'h0);

  always_comb begin
    isJump  = 1'b0;
    isSkip  = 1'b0;
    isLegal = 1'b1;
    case (opc)
      OP_SYS: begin
        isJump  = (curWord != WORD_CLEAR) && (curWord != WORD_RETURN);
        isLegal = isJump;
      end
      OP_JUMP:  isJump = 1'b1;
      OP_SEQ_K: isSkip = (regValX == curWord[7:0]);
      OP_SNE_K: isSkip = (regValX != curWord[7:0]);
      OP_SEQ_R: begin
        isLegal = lowZero;
        isSkip  = lowZero && (regValX == regValY);
      end
      OP_SNE_R: begin
        isLegal = lowZero;
        isSkip  = lowZero && (regValX != regValY);
      end
      default: isLegal = 1'b0;
    endcase
  end

  always_comb begin
    if (isJump)      pcNext = ADDR_W'(curWord[11:0]);
    else if (isSkip) pcNext = pcReg + STEP + STEP;
    else             pcNext = pcReg + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcReg   <= PC_INIT;
      execPc  <= PC_INIT;
      hiByte  <= '0;
      wordReg <= '0;
      doneReg <= 1'b0;
      illReg  <= 1'b0;
      wasJump <= 1'b0;
      wasSkip <= 1'b0;
    end else begin
      doneReg <= strobe.execute;
      illReg  <= strobe.execute && !isLegal;
      if (strobe.issueLo) hiByte <= memRdData;
      if (strobe.execute) begin
        pcReg   <= pcNext;
        execPc  <= pcReg;
        wordReg <= curWord;
        wasJump <= isJump;
        wasSkip <= isSkip;
      end
    end
  end

  assign memRdEn   = strobe.issueHi || strobe.issueLo;
  assign memAddr   = strobe.issueLo ? pcReg + NEXT_BYTE : pcReg;
  assign regIdxX   = hiByte[3:0];
  assign regIdxY   = memRdData[7:4];
  assign pc        = pcReg;
  assign instrWord = wordReg;
  assign done      = doneReg;
  assign illegal   = illReg;

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wasJump && !wasSkip) |-> (pc == execPc + STEP)); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wasJump) |-> (pc == ADDR_W'(instrWord[11:0]))); // R4
  AST_SKIP_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wasSkip) |-> (pc == execPc + STEP + STEP)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && pc == execPc + STEP)); // R9
  AST_LO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issueLo |-> (memAddr == $past(memAddr) + NEXT_BYTE)); // R8
  AST_EXEC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.execute |-> !memRdEn); // R11
endmodule

// File: rtl/fetchSeqUnit.sv
`timescale 1ns/1ps
module fetchSeqUnit
  import fetchSeqPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RESET_PC = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [7:0]        memRdData,
  output logic [3:0]        regIdxX,
  output logic [3:0]        regIdxY,
  input  logic [7:0]        regValX,
  input  logic [7:0]        regValY,
  output logic [ADDR_W-1:0] pc,
  output logic [15:0]       instrWord,
  output logic [3:0]        fieldX,
  output logic [3:0]        fieldY,
  output logic [7:0]        fieldKk,
  output logic [11:0]       fieldNnn,
  output logic [3:0]        fieldN,
  output logic              done,
  output logic              illegal
);
  fetchStrobe_t strobe;

  fetchSeqCtrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobe (strobe)
  );

  fetchSeqPath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .memRdData (memRdData),
    .regValX   (regValX),
    .regValY   (regValY),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .regIdxX   (regIdxX),
    .regIdxY   (regIdxY),
    .pc        (pc),
    .instrWord (instrWord),
    .done      (done),
    .illegal   (illegal)
  );

  assign fieldX   = instrWord[11:8];
  assign fieldY   = instrWord[7:4];
  assign fieldKk  = instrWord[7:0];
  assign fieldNnn = instrWord[11:0];
  assign fieldN   = instrWord[3:0];

  AST_FIELDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fieldNnn == {fieldX, fieldKk})); // R10
endmodule

// File: tb/fetchSeqUnit_bench.sv
`timescale 1ns/1ps
module fetchSeqUnit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] memAddr;
  logic        memRdEn;
  logic [7:0]  memRdData;
  logic [3:0]  regIdxX, regIdxY;
  logic [7:0]  regValX, regValY;
  logic [11:0] pc;
  logic [15:0] instrWord;
  logic [3:0]  fieldX, fieldY, fieldN;
  logic [7:0]  fieldKk;
  logic [11:0] fieldNnn;
  logic        done, illegal;

  logic [7:0] mem [0:4095];
  logic [7:0] regs [0:15];
  int checks = 0;
  int failures = 0;
  logic [11:0] expPc;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];
  assign regValX = regs[regIdxX];
  assign regValY = regs[regIdxY];

  fetchSeqUnit u_fetchSeqUnit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .regIdxX(regIdxX), .regIdxY(regIdxY), .regValX(regValX), .regValY(regValY),
    .pc(pc), .instrWord(instrWord), .fieldX(fieldX), .fieldY(fieldY),
    .fieldKk(fieldKk), .fieldNnn(fieldNnn), .fieldN(fieldN),
    .done(done), .illegal(illegal)
  );

  // kind: 0 = +2, 1 = +4, 2 = jump to nnn
  typedef struct packed {
    logic [15:0] w;
    logic [7:0]  xv;
    logic [7:0]  yv;
    logic [1:0]  kind;
    logic        ill;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'h1ABC, 8'h00, 8'h00, 2'd2, 1'b0},
    '{16'h0123, 8'h00, 8'h00, 2'd2, 1'b0},
    '{16'h00E0, 8'h00, 8'h00, 2'd0, 1'b1},
    '{16'h00EE, 8'h00, 8'h00, 2'd0, 1'b1},
    '{16'h3284, 8'h84, 8'h00, 2'd1, 1'b0},
    '{16'h3248, 8'h84, 8'h00, 2'd0, 1'b0},
    '{16'h4284, 8'h84, 8'h00, 2'd0, 1'b0},
    '{16'h4248, 8'h84, 8'h00, 2'd1, 1'b0},
    '{16'h5120, 8'h84, 8'h84, 2'd1, 1'b0},
    '{16'h5120, 8'h84, 8'h48, 2'd0, 1'b0},
    '{16'h9120, 8'h84, 8'h48, 2'd1, 1'b0},
    '{16'h9120, 8'h33, 8'h33, 2'd0, 1'b0},
    '{16'h5121, 8'h33, 8'h33, 2'd0, 1'b1},
    '{16'h9341, 8'h01, 8'h02, 2'd0, 1'b1},
    '{16'h6A55, 8'h00, 8'h00, 2'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [15:0] w, input logic ill);
    if (ill) return "R9";
    case (w[15:12])
      4'h0, 4'h1: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic execOne(input logic [15:0] w, input logic [7:0] xv, input logic [7:0] yv,
                         input logic [1:0] kind, input logic ill, input string tag);
    logic [11:0] a = expPc;
    mem[a] = w[15:8];
    mem[a + 12'd1] = w[7:0];
    regs[w[11:8]] = xv;
    regs[w[7:4]]  = yv;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 0; n < 8 && !done; n++) @(negedge clk);
    case (kind)
      2'd1:    expPc = a + 12'd4;
      2'd2:    expPc = w[11:0];
      default: expPc = a + 12'd2;
    endcase
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " pc"}, 32'(pc), 32'(expPc));
    chk({tag, " illegal"}, 32'(illegal), 32'(ill));
    chk({"R2 word ", tag}, 32'(instrWord), 32'(w));
    chk("R10 fields", {fieldX, fieldY, fieldN, fieldKk, fieldNnn}, {w[11:8], w[7:4], w[3:0], w[7:0], w[11:0]});
    @(negedge clk);
    chk("R3 done single", 32'(done), 32'd0);
    chk("R9 illegal single", 32'(illegal), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", 32'(pc), 32'h200);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset", 32'(pc), 32'h200);
    chk("R1 illegal after reset", 32'(illegal), 32'd0);
    chk("R1 no read after reset", 32'(memRdEn), 32'd0);

    // Detailed cycle walk: 0x5340 at 0x200, V3 == V4 -> skip
    mem[12'h200] = 8'h53; mem[12'h201] = 8'h40;
    regs[3] = 8'h07; regs[4] = 8'h07;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 hi request", 32'(memRdEn), 32'd1);
    chk("R2 hi address", 32'(memAddr), 32'h200);
    @(negedge clk);
    chk("R2 lo request", 32'(memRdEn), 32'd1);
    chk("R2 lo address", 32'(memAddr), 32'h201);
    @(negedge clk);
    chk("R11 no read in execute", 32'(memRdEn), 32'd0);
    chk("R11 index x", 32'(regIdxX), 32'h3);
    chk("R11 index y", 32'(regIdxY), 32'h4);
    chk("R3 no early done", 32'(done), 32'd0);
    @(negedge clk);
    chk("R3 done timing", 32'(done), 32'd1);
    chk("R7 skip equal regs", 32'(pc), 32'h204);
    chk("R2 word", 32'(instrWord), 32'h5340);
    @(negedge clk);
    chk("R3 done one cycle", 32'(done), 32'd0);
    expPc = 12'h204;

    for (int v = 0; v < NV; v++)
      execOne(VECS[v].w, VECS[v].xv, VECS[v].yv, VECS[v].kind, VECS[v].ill,
              tagFor(VECS[v].w, VECS[v].ill));

    // R8 wrap cases
    execOne(16'h1FFE, 8'h00, 8'h00, 2'd2, 1'b0, "R4");
    execOne(16'h3248, 8'h84, 8'h00, 2'd0, 1'b0, "R8");
    chk("R8 advance wraps", 32'(pc), 32'h000);
    execOne(16'h1FFE, 8'h00, 8'h00, 2'd2, 1'b0, "R4");
    execOne(16'h3284, 8'h84, 8'h00, 2'd1, 1'b0, "R8");
    chk("R8 skip wraps", 32'(pc), 32'h002);
    execOne(16'h1FFF, 8'h00, 8'h00, 2'd2, 1'b0, "R4");
    execOne(16'h4148, 8'h48, 8'h00, 2'd0, 1'b0, "R8");
    chk("R8 straddle word", 32'(instrWord), 32'h4148);
    chk("R8 straddle pc", 32'(pc), 32'h001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule